// File: doc/BRIEF.md
# Boot Image Loader with Fallback

This block is the hardware sequencer that brings a system up after reset. It asks an external flash-streaming agent for a boot image of fixed length. The first request goes to a primary flash offset. Each byte that arrives is written into system memory, starting at a fixed load base. A CRC-16 is computed over the payload and compared with the two checksum bytes at the end of the image. When the check passes, the block emits a one-cycle start request together with the entry address.

A failed primary copy turns the status colour to magenta, with the blink flag set, and the block requests a secondary copy from a second flash offset. If that copy fails too, the colour turns grey. The block then waits for an image on a byte-serial link. A serial image is checked in the same way. A serial failure returns the block to waiting for a fresh serial image and never back to flash.

If the three joystick inputs (up, right and fire) are all held on the first clock after reset, both flash attempts are skipped and the block goes straight to the serial path. The flash and serial physical layers are outside the block and appear as valid/ready byte streams.

The states are IDLE, FETCH_PRIMARY, FETCH_SECONDARY, SERIAL_WAIT, CHECK and DONE. The transitions are:
- IDLE goes to FETCH_PRIMARY, or to SERIAL_WAIT when the chord is held.
- Each loading state goes to CHECK once the last byte's memory write has been acknowledged.
- CHECK goes to DONE when the checksum matches.
- When the checksum does not match, CHECK goes to FETCH_SECONDARY after the primary copy, and to SERIAL_WAIT after the secondary copy or a serial image.
- DONE stays in DONE until the next reset.

Top module: `boot_loader`

## Requirements
- R1: While reset is held, flash_req, mem_we, start_pulse, flash_ready and ser_ready are all 0 and colour is 0 (booting).
- R2: Unless up, right and fire are all high on the first clock after reset, the block pulses flash_req for one cycle with flash_offset = PRI_OFS (default 0x0F000) and flash_len = IMG_LEN (default 3520).
- R3: Each accepted byte k of an image is written to mem_addr = LOAD_BASE + k (default base 0x0200). mem_we, mem_addr and mem_wdata are held until mem_ack. No byte is accepted while a write is pending.
- R4: The checksum is a bytewise CRC-16, MSB first, with polynomial CRC_POLY (default 0x1021) and initial value CRC_INIT (default 0xFFFF). It covers bytes 0 to IMG_LEN-3 and must equal byte IMG_LEN-2 (high) concatenated with byte IMG_LEN-1 (low).
- R5: When an image passes, start_pulse is high for exactly one cycle with entry_addr = ENTRY (default 0x0200). colour then becomes 3 (OK), and no further flash request or ready follows.
- R6: When the primary image fails, the block pulses flash_req with flash_offset = SEC_OFS (default 0x1F000). At that point colour is 1 (magenta) and status_blink is 1.
- R7: When the secondary image fails, colour becomes 2 (grey), ser_ready is offered, and no further flash request is made.
- R8: If up, right and fire are all high on the first clock after reset, no flash request is made and the serial path starts at once. If any one of the three is low, the primary fetch is made.
- R9: A failed serial image leaves the block on the serial path. It accepts a fresh image from byte 0 and makes no flash request.
- R10: flash_ready is high only in a flash-fetch state, and never in the cycle of flash_req. ser_ready is high only in SERIAL_WAIT. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| joy_up | input | 1 | Joystick up, used for the chord |
| joy_right | input | 1 | Joystick right, used for the chord |
| joy_fire | input | 1 | Joystick fire, used for the chord |
| flash_req | output | 1 | One-cycle pulse that starts a flash stream |
| flash_offset | output | 20 | Flash start offset of the requested stream |
| flash_len | output | 16 | Byte count of the requested stream |
| flash_valid | input | 1 | Flash byte valid |
| flash_data | input | 8 | Flash byte |
| flash_ready | output | 1 | Block accepts a flash byte |
| ser_valid | input | 1 | Serial byte valid |
| ser_data | input | 8 | Serial byte |
| ser_ready | output | 1 | Block accepts a serial byte |
| mem_we | output | 1 | Memory write request, held until acknowledged |
| mem_addr | output | 16 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |
| start_pulse | output | 1 | One-cycle start request |
| entry_addr | output | 16 | Entry address given with the start request |
| colour | output | 2 | Status colour: 0 booting, 1 magenta, 2 grey, 3 OK |
| status_blink | output | 1 | High while the magenta colour should flash |

## Verification
The assertions assume three things about the inputs:
- A stream source keeps valid and its data steady until the byte is taken.
- The flash agent streams only after a request.
- The memory acknowledges only while a write is pending.

The bench's flash and serial agents hold each offered byte until the handshake completes and insert idle gaps only between bytes. The flash agent restarts its stream at byte 0 on every request. The memory model asserts mem_ack only alongside mem_we and stalls every other cycle, so the hold rule for writes is exercised. Under these conditions, the bench can predict every write from the bytes it hands over.

// File: rtl/boot_pkg.sv
package boot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_PRIMARY,
        ST_CHECK,
        ST_FETCH_SECONDARY,
        ST_SERIAL_WAIT,
        ST_DONE
    } boot_state_e;

    typedef enum logic [1:0] {
        COL_BOOT    = 2'd0,
        COL_MAGENTA = 2'd1,
        COL_GREY    = 2'd2,
        COL_OK      = 2'd3
    } colour_e;

    typedef enum logic [1:0] {
        SRC_PRIMARY,
        SRC_SECONDARY,
        SRC_SERIAL
    } image_src_e;
endpackage

// File: rtl/boot_crc16.sv
module boot_crc16 #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    // Feed the byte in one bit at a time, most significant bit first.
    function automatic logic [15:0] byte_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc <= INIT;
        else if (clear) crc <= INIT;
        else if (en)    crc <= byte_step(crc, din);
    end
endmodule

// File: rtl/boot_mem_writer.sv
module boot_mem_writer #(
    parameter int            AW   = 16,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          mem_ack,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          busy
);
    logic [AW-1:0] next_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= BASE;
            mem_wdata <= '0;
            next_addr <= BASE;
        end else if (restart) begin
            next_addr <= BASE;
        end else if (push) begin
            mem_we    <= 1'b1;
            mem_addr  <= next_addr;
            mem_wdata <= push_data;
            next_addr <= next_addr + 1'b1;
        end else if (mem_we && mem_ack) begin
            mem_we <= 1'b0;
        end
    end

    assign busy = mem_we;
endmodule

// File: rtl/boot_loader.sv
module boot_loader
    import boot_pkg::*;
#(
    parameter int          IMG_LEN   = 3520,
    parameter logic [19:0] PRI_OFS   = 20'h0F000,
    parameter logic [19:0] SEC_OFS   = 20'h1F000,
    parameter logic [15:0] LOAD_BASE = 16'h0200,
    parameter logic [15:0] ENTRY     = 16'h0200,
    parameter logic [15:0] CRC_POLY  = 16'h1021,
    parameter logic [15:0] CRC_INIT  = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        joy_up,
    input  logic        joy_right,
    input  logic        joy_fire,
    output logic        flash_req,
    output logic [19:0] flash_offset,
    output logic [15:0] flash_len,
    input  logic        flash_valid,
    input  logic [7:0]  flash_data,
    output logic        flash_ready,
    input  logic        ser_valid,
    input  logic [7:0]  ser_data,
    output logic        ser_ready,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic        mem_ack,
    output logic        start_pulse,
    output logic [15:0] entry_addr,
    output logic [1:0]  colour,
    output logic        status_blink
);
    localparam int          CW      = $clog2(IMG_LEN + 1);
    localparam logic [CW-1:0] LAST  = CW'(IMG_LEN);
    localparam logic [CW-1:0] CHK_HI = CW'(IMG_LEN - 2);
    localparam logic [CW-1:0] CHK_LO = CW'(IMG_LEN - 1);

    boot_state_e state, nxt;
    image_src_e  src;
    colour_e     col_q;
    logic [CW-1:0] cnt;
    logic [7:0]  chk_hi, chk_lo;
    logic [15:0] crc;
    logic        wr_busy, in_flash, in_serial, take_rdy, in_valid, accept;
    logic        load_start, load_done, crc_ok, chord;
    logic [7:0]  in_data;

    assign chord     = joy_up & joy_right & joy_fire;
    assign in_flash  = (state == ST_FETCH_PRIMARY) || (state == ST_FETCH_SECONDARY);
    assign in_serial = (state == ST_SERIAL_WAIT);
    assign take_rdy  = ((in_flash && !flash_req) || in_serial) && !wr_busy && (cnt != LAST);
    assign flash_ready = take_rdy && in_flash;
    assign ser_ready   = take_rdy && in_serial;
    assign in_valid  = in_flash ? flash_valid : ser_valid;
    assign in_data   = in_flash ? flash_data  : ser_data;
    assign accept    = take_rdy && in_valid;
    assign load_done = (cnt == LAST) && !wr_busy;
    assign crc_ok    = (crc == {chk_hi, chk_lo});
    assign load_start = (nxt != state) &&
                        ((nxt == ST_FETCH_PRIMARY) || (nxt == ST_FETCH_SECONDARY) ||
                         (nxt == ST_SERIAL_WAIT));

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:            nxt = chord ? ST_SERIAL_WAIT : ST_FETCH_PRIMARY;
            ST_FETCH_PRIMARY,
            ST_FETCH_SECONDARY,
            ST_SERIAL_WAIT:     if (load_done) nxt = ST_CHECK;
            ST_CHECK: begin
                if (crc_ok)                    nxt = ST_DONE;
                else if (src == SRC_PRIMARY)   nxt = ST_FETCH_SECONDARY;
                else                           nxt = ST_SERIAL_WAIT;
            end
            ST_DONE:            nxt = ST_DONE;
            default:            nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Image datapath: byte count, source and checksum capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            src    <= SRC_PRIMARY;
            chk_hi <= '0;
            chk_lo <= '0;
        end else if (load_start) begin
            cnt <= '0;
            unique case (nxt)
                ST_FETCH_PRIMARY:   src <= SRC_PRIMARY;
                ST_FETCH_SECONDARY: src <= SRC_SECONDARY;
                default:            src <= SRC_SERIAL;
            endcase
        end else if (accept) begin
            cnt <= cnt + 1'b1;
            if (cnt == CHK_HI) chk_hi <= in_data;
            if (cnt == CHK_LO) chk_lo <= in_data;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flash_req    <= 1'b0;
            flash_offset <= PRI_OFS;
            start_pulse  <= 1'b0;
            col_q        <= COL_BOOT;
        end else begin
            flash_req   <= load_start &&
                           ((nxt == ST_FETCH_PRIMARY) || (nxt == ST_FETCH_SECONDARY));
            start_pulse <= (nxt == ST_DONE) && (state != ST_DONE);
            if (load_start && (nxt == ST_FETCH_PRIMARY))   flash_offset <= PRI_OFS;
            if (load_start && (nxt == ST_FETCH_SECONDARY)) flash_offset <= SEC_OFS;
            unique case (nxt)
                ST_FETCH_PRIMARY:   col_q <= COL_BOOT;
                ST_FETCH_SECONDARY: col_q <= COL_MAGENTA;
                ST_SERIAL_WAIT:     col_q <= COL_GREY;
                ST_DONE:            col_q <= COL_OK;
                default:            col_q <= col_q;
            endcase
        end
    end

    assign flash_len    = 16'(IMG_LEN);
    assign entry_addr   = ENTRY;
    assign colour       = col_q;
    assign status_blink = (col_q == COL_MAGENTA);

    boot_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load_start),
        .en    (accept && (cnt < CHK_HI)),
        .din   (in_data),
        .crc   (crc)
    );

    boot_mem_writer #(.AW(16), .BASE(LOAD_BASE)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (load_start),
        .push      (accept),
        .push_data (in_data),
        .mem_ack   (mem_ack),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .busy      (wr_busy)
    );
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
    parameter int          IMG_LEN = 3520,
    parameter logic [19:0] PRI_OFS = 20'h0F000,
    parameter logic [19:0] SEC_OFS = 20'h1F000,
    parameter logic [15:0] ENTRY   = 16'h0200
) (
    input logic        clk,
    input logic        rst_n,
    input logic        flash_req,
    input logic [19:0] flash_offset,
    input logic [15:0] flash_len,
    input logic        flash_ready,
    input logic        ser_ready,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_ack,
    input logic        start_pulse,
    input logic [15:0] entry_addr,
    input logic [1:0]  colour
);
    // R5
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    // R5
    start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (entry_addr == ENTRY));
    // R5
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (colour == 2'd3) |=> (colour == 2'd3) && !flash_ready && !ser_ready && !flash_req);
    // R3
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ack) |=> mem_we && $stable(mem_addr) && $stable(mem_wdata));
    // R3
    no_take_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_ready || ser_ready) |-> !mem_we);
    // R10
    ready_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_ready && ser_ready));
    // R10
    no_ready_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_req |-> !flash_ready);
    // R2
    req_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_req |-> ((flash_offset == PRI_OFS) || (flash_offset == SEC_OFS)) &&
                      (flash_len == 16'(IMG_LEN)));
    // R10
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_req |=> !flash_req);
    // R7
    serial_grey_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_ready |-> (colour == 2'd2));
endmodule

bind boot_loader boot_loader_chk #(
    .IMG_LEN (IMG_LEN),
    .PRI_OFS (PRI_OFS),
    .SEC_OFS (SEC_OFS),
    .ENTRY   (ENTRY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flash_req    (flash_req),
    .flash_offset (flash_offset),
    .flash_len    (flash_len),
    .flash_ready  (flash_ready),
    .ser_ready    (ser_ready),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .start_pulse  (start_pulse),
    .entry_addr   (entry_addr),
    .colour       (colour)
);

// File: tb/boot_loader_test.sv
module boot_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int LEN        = 24;
    localparam int PRI        = 32'h0F000;
    localparam int SEC        = 32'h1F000;
    localparam int BASE       = 32'h0200;
    localparam int POLY       = 32'h1021;
    localparam int INIT       = 32'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        joy_up = 1'b0, joy_right = 1'b0, joy_fire = 1'b0;
    logic        flash_req, flash_ready, ser_ready;
    logic [19:0] flash_offset;
    logic [15:0] flash_len;
    logic        flash_valid = 1'b0, ser_valid = 1'b0, mem_ack = 1'b0;
    logic [7:0]  flash_data = '0, ser_data = '0;
    logic        mem_we, start_pulse, status_blink;
    logic [15:0] mem_addr, entry_addr;
    logic [7:0]  mem_wdata;
    logic [1:0]  colour;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_loader #(.IMG_LEN(LEN)) uut (
        .clk(clk), .rst_n(rst_n),
        .joy_up(joy_up), .joy_right(joy_right), .joy_fire(joy_fire),
        .flash_req(flash_req), .flash_offset(flash_offset), .flash_len(flash_len),
        .flash_valid(flash_valid), .flash_data(flash_data), .flash_ready(flash_ready),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_ready(ser_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .start_pulse(start_pulse), .entry_addr(entry_addr),
        .colour(colour), .status_blink(status_blink)
    );

    int checks = 0, failures = 0;
    logic [7:0] img [4][LEN];   // 0 primary, 1 secondary, 2/3 serial images
    int exp_q[$];               // {addr, data} packed as addr*256+data
    int n_ser, n_req, n_start, n_wr, cyc;
    int req_ofs [4];
    bit mag_ok, col_bad, gap_seen;
    int fl_ptr, fl_sel, sr_ptr, sr_img;
    bit fl_fire, sr_fire, ack_tog;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int crc_ref(input int k);
        int c = INIT;
        for (int i = 0; i < LEN - 2; i++) begin
            c = c ^ (int'(img[k][i]) << 8);
            for (int b = 0; b < 8; b++)
                c = (c & 32'h8000) != 0 ? ((c << 1) ^ POLY) & 32'hFFFF : (c << 1) & 32'hFFFF;
        end
        return c;
    endfunction

    task automatic build(input int k, input int seed, input bit good);
        int c;
        for (int i = 0; i < LEN - 2; i++) img[k][i] = 8'(seed * 37 + i * 11 + 3);
        c = crc_ref(k);
        img[k][LEN-2] = 8'(c >> 8);
        img[k][LEN-1] = 8'(c);
        if (!good) img[k][5] = img[k][5] ^ 8'h10;   // payload corrupted after checksum
    endtask

    // Stimulus and reference model, all on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                fl_ptr = 0; fl_sel = -1; fl_fire = 0; sr_fire = 0;
                flash_valid = 0; ser_valid = 0; mem_ack = 0;
            end else begin
                // transfers that completed at the last rising edge
                if (fl_fire) begin
                    exp_q.push_back((BASE + fl_ptr) * 256 + int'(img[fl_sel][fl_ptr]));
                    fl_ptr++;
                end
                if (sr_fire) begin
                    exp_q.push_back((BASE + sr_ptr) * 256 + int'(img[2 + sr_img][sr_ptr]));
                    sr_ptr++;
                    if (sr_ptr == LEN) begin sr_ptr = 0; sr_img++; end
                end
                if (flash_req) begin
                    if (n_req < 4) req_ofs[n_req] = int'(flash_offset);
                    n_req++;
                    if (int'(flash_offset) == SEC) mag_ok = (colour == 2'd1) && status_blink;
                    chk(flash_len == 16'(LEN), "R2", "flash_len", int'(flash_len), LEN);
                    fl_ptr = 0;
                    fl_sel = (int'(flash_offset) == PRI) ? 0 : (int'(flash_offset) == SEC) ? 1 : -1;
                    flash_valid = 0;
                    fl_fire = 0;
                end
                // memory model: acknowledge every other cycle
                ack_tog = !ack_tog;
                mem_ack = mem_we && ack_tog;
                if (mem_ack) begin
                    int e;
                    n_wr++;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                    chk(int'(mem_addr) * 256 + int'(mem_wdata) == e, "R3", "write addr*256+data",
                        int'(mem_addr) * 256 + int'(mem_wdata), e);
                end
                if (start_pulse) begin
                    n_start++;
                    chk(entry_addr == 16'h0200, "R5", "entry_addr", int'(entry_addr), 32'h200);
                end
                if (ser_ready && colour != 2'd2) col_bad = 1;
                if (flash_ready && ser_ready) col_bad = 1;      // R10
                if (flash_ready && flash_req) col_bad = 1;     // R10
                // flash source: hold a pending byte, otherwise offer with gaps
                if (!(flash_valid && !fl_fire)) begin
                    flash_valid = (fl_sel >= 0) && (fl_ptr < LEN) && ((cyc % 7) != 3);
                    if ((cyc % 7) == 3) gap_seen = 1;
                end
                if (fl_sel >= 0 && fl_ptr < LEN) flash_data = img[fl_sel][fl_ptr];
                fl_fire = flash_valid && flash_ready;
                // serial source
                if (!(ser_valid && !sr_fire))
                    ser_valid = (sr_img < n_ser) && ((cyc % 5) != 1);
                if (sr_img < n_ser) ser_data = img[2 + sr_img][sr_ptr];
                sr_fire = ser_valid && ser_ready;
            end
        end
    end

    task automatic run(input string name, input bit ju, input bit jr, input bit jf,
                       input bit pg, input bit sg, input int ns, input bit s0g, input bit s1g,
                       input int seed);
        build(0, seed, pg); build(1, seed + 1, sg);
        build(2, seed + 2, s0g); build(3, seed + 3, s1g);
        rst_n = 0;
        n_ser = ns; n_req = 0; n_start = 0; n_wr = 0; sr_ptr = 0; sr_img = 0;
        mag_ok = 0; col_bad = 0; exp_q.delete();
        joy_up = ju; joy_right = jr; joy_fire = jf;
        repeat (3) @(negedge clk);
        // R1: state under reset
        chk(!flash_req && !mem_we && !start_pulse && !flash_ready && !ser_ready && colour == 2'd0,
            "R1", {name, " reset outputs"},
            {flash_req, mem_we, start_pulse, flash_ready, ser_ready, colour}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        joy_up = 0; joy_right = 0; joy_fire = 0;
        for (int t = 0; t < 3000 && n_start == 0; t++) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(n_start == 1, "R5", {name, " start pulses"}, n_start, 1);
        chk(colour == 2'd3 && !status_blink, "R5", {name, " final colour"}, int'(colour), 3);
        chk(!col_bad, "R10", {name, " ready/colour rules"}, col_bad, 0);
        chk(exp_q.size() == 0, "R3", {name, " writes outstanding"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // good primary copy
        run("A", 0, 0, 0, 1, 1, 0, 1, 1, 1);
        chk(n_req == 1, "R2", "A flash requests", n_req, 1);
        chk(req_ofs[0] == PRI, "R2", "A primary offset", req_ofs[0], PRI);
        chk(n_wr == LEN, "R3", "A write count", n_wr, LEN);
        chk(gap_seen, "R3", "A source gaps exercised", gap_seen, 1);

        // primary corrupted, secondary good: checksum rejects the bad copy
        run("B", 0, 0, 0, 0, 1, 0, 1, 1, 9);
        chk(n_req == 2, "R4", "B bad primary rejected", n_req, 2);
        chk(req_ofs[1] == SEC, "R6", "B secondary offset", req_ofs[1], SEC);
        chk(mag_ok, "R6", "B magenta blink at retry", mag_ok, 1);
        chk(n_wr == 2 * LEN, "R3", "B write count", n_wr, 2 * LEN);

        // both flash copies bad, serial good
        run("C", 0, 0, 0, 0, 0, 1, 1, 1, 21);
        chk(n_req == 2, "R7", "C no third flash request", n_req, 2);
        chk(n_wr == 3 * LEN, "R7", "C serial image written", n_wr, 3 * LEN);

        // chord held: serial only; first serial image bad, second good
        run("D", 1, 1, 1, 1, 1, 2, 0, 1, 33);
        chk(n_req == 0, "R8", "D chord skips flash", n_req, 0);
        chk(n_wr == 2 * LEN, "R9", "D fresh serial image after failure", n_wr, 2 * LEN);

        // partial chord: flash path still taken
        run("E", 1, 1, 0, 1, 1, 0, 1, 1, 47);
        chk(n_req == 1 && req_ofs[0] == PRI, "R8", "E partial chord uses flash", n_req, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule